// File: doc/BRIEF.md
# Isochronous Cycle Loss Detector

This block follows the isochronous cycle timing of a serial bus and reports cycles that went missing. It is fed with single-cycle strobes from neighbouring logic. These are the interval boundary (raised whenever the low-order bit of the cycle count toggles), a cycle-start packet seen on the bus (sent or received), a subaction gap, an arbitration reset gap, and any other packet. From these it produces a one-cycle `cycle_lost_o` pulse. Elsewhere that pulse sets a sticky event flag.

A loss is reported in one of two ways. It can be reported late, when an interval boundary arrives and no cycle-start packet came since the previous boundary. It can also be reported early, from the order in which gaps and packets follow the boundary. In that case the block does not wait for the next boundary. The early path can be removed with the `PREDICT_EN` parameter. Each interval produces at most one pulse, so a loss that was predicted is not reported again at the next boundary. After reset, the first boundary only arms the detector.

Top module: `cycle_loss_detector`

## Requirements
- R1: While reset is asserted and after it is released, `cycle_lost_o` is 0 and the detector is disarmed.
- R2: The first `synch_i` after reset arms the detector and never produces a pulse.
- R3: When `synch_i` arrives while armed, with no `start_i` since the previous `synch_i` and no pulse yet in that interval, `cycle_lost_o` is 1 for exactly the one cycle after that `synch_i`.
- R4: A `start_i` in any state marks the interval as started. A later `synch_i` in that case gives no pulse. A `start_i` in the same cycle as `synch_i` counts for the interval that `synch_i` opens.
- R5: With `PREDICT_EN`=1, the block predicts a loss when, after the first `subgap_i` of an interval, a second `subgap_i`, an `arbgap_i` or a `pkt_i` arrives before any `start_i`. The pulse comes in the cycle after that event.
- R6: With `PREDICT_EN`=1, an `arbgap_i` after `synch_i` with no `start_i` in between predicts a loss. This holds whether or not a subaction gap came first, and the pulse comes in the next cycle.
- R7: At most one pulse is produced per interval. A predicted loss is not reported again at the next `synch_i`, and later failing events in the same interval give no pulse.
- R8: A `start_i` in the same cycle as a predicting event (without `synch_i`) wins, and no pulse follows.
- R9: With `PREDICT_EN`=0, pulses occur only in the cycle after a `synch_i`, following the rule of R3.
- R10: Gap and packet strobes before the first `synch_i` after reset are ignored. A `pkt_i` before the first `subgap_i` of an interval is also ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| synch_i | input | 1 | Strobe: new isochronous interval begins |
| start_i | input | 1 | Strobe: cycle-start packet sent or received |
| subgap_i | input | 1 | Strobe: subaction gap detected |
| arbgap_i | input | 1 | Strobe: arbitration reset gap detected |
| pkt_i | input | 1 | Strobe: a packet other than a cycle start seen |
| cycle_lost_o | output | 1 | One-cycle pulse: a cycle was lost or is predicted lost |

## Verification
Two instances run side by side, one with prediction on and one with it off. A behavioural model is compared against both on every clock. The directed patterns cover several cases:
- Missing starts separate the late report from the early one.
- A start coinciding with the boundary checks which interval that start belongs to.
- Gap-then-gap, gap-then-packet and arbitration-gap orderings tell the three prediction triggers apart.
- A prediction followed by a boundary exposes a doubled report.

Strobes before arming, and a start in the same cycle as a trigger, check what must be ignored. A long random run with sparse strobes then mixes all orderings.

// File: rtl/cld_pkg.sv
package cld_pkg;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_WAIT_GAP   = 2'd1,
        ST_WAIT_START = 2'd2,
        ST_STARTED    = 2'd3
    } cld_state_e;

    typedef struct packed {
        cld_state_e state;
        logic       armed;
    } seq_regs_t;

    typedef struct packed {
        logic reported;
        logic lost;
    } gate_regs_t;

endpackage

// File: rtl/cld_seq.sv
module cld_seq
    import cld_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       synch_i,
    input  logic       start_i,
    input  logic       subgap_i,
    input  logic       arbgap_i,
    input  logic       pkt_i,
    output cld_state_e state_o,
    output logic       armed_o,
    output logic       miss_o,
    output logic       pred_o
);

    seq_regs_t r_q, r_d;
    logic      miss_d, pred_d;

    always_comb begin
        r_d    = r_q;
        miss_d = 1'b0;
        pred_d = 1'b0;
        if (synch_i) begin
            // interval boundary: judge the interval that just closed
            miss_d    = r_q.armed && (r_q.state != ST_STARTED);
            r_d.armed = 1'b1;
            r_d.state = start_i ? ST_STARTED : ST_WAIT_GAP;
        end else if (start_i) begin
            r_d.state = ST_STARTED;
        end else begin
            unique case (r_q.state)
                ST_WAIT_GAP: begin
                    if (arbgap_i) begin
                        pred_d = 1'b1;
                    end else if (subgap_i) begin
                        r_d.state = ST_WAIT_START;
                    end
                end
                ST_WAIT_START: begin
                    if (subgap_i || arbgap_i || pkt_i) begin
                        pred_d = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, armed: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.state;
    assign armed_o = r_q.armed;
    assign miss_o  = miss_d;
    assign pred_o  = pred_d;

    // R4: a start without a boundary always lands in the started state
    a_r4_start_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !synch_i) |=> (r_q.state == ST_STARTED));

    // R2: a boundary always leaves the detector armed
    a_r2_synch_arms: assert property (@(posedge clk) disable iff (!rst_n)
        synch_i |=> r_q.armed);

    // R10: once left, the idle state is never re-entered
    a_r10_no_return_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != ST_IDLE) |=> (r_q.state != ST_IDLE));

endmodule

// File: rtl/cld_gate.sv
module cld_gate
    import cld_pkg::*;
#(
    parameter bit PREDICT_EN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic synch_i,
    input  logic miss_i,
    input  logic pred_i,
    output logic lost_o
);

    gate_regs_t g_q, g_d;
    logic       pred_use;
    logic       fire;

    generate
        if (PREDICT_EN) begin : g_pred_on
            assign pred_use = pred_i;
        end else begin : g_pred_off
            assign pred_use = 1'b0;
        end
    endgenerate

    always_comb begin
        fire       = !g_q.reported && (miss_i || pred_use);
        g_d.lost   = fire;
        g_d.reported = synch_i ? 1'b0 : (g_q.reported || fire);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '{reported: 1'b0, lost: 1'b0};
        end else begin
            g_q <= g_d;
        end
    end

    assign lost_o = g_q.lost;

    // R7: once an interval has reported, nothing more comes out of it
    a_r7_once_per_interval: assert property (@(posedge clk) disable iff (!rst_n)
        (g_q.reported && !synch_i) |=> !g_q.lost);

endmodule

// File: rtl/cycle_loss_detector.sv
module cycle_loss_detector
    import cld_pkg::*;
#(
    parameter bit PREDICT_EN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic synch_i,
    input  logic start_i,
    input  logic subgap_i,
    input  logic arbgap_i,
    input  logic pkt_i,
    output logic cycle_lost_o
);

    cld_state_e state;
    logic       armed;
    logic       miss;
    logic       pred;

    cld_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .synch_i  (synch_i),
        .start_i  (start_i),
        .subgap_i (subgap_i),
        .arbgap_i (arbgap_i),
        .pkt_i    (pkt_i),
        .state_o  (state),
        .armed_o  (armed),
        .miss_o   (miss),
        .pred_o   (pred)
    );

    cld_gate #(
        .PREDICT_EN (PREDICT_EN)
    ) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .synch_i (synch_i),
        .miss_i  (miss),
        .pred_i  (pred),
        .lost_o  (cycle_lost_o)
    );

    // R1: a pulse is only possible once the detector is armed
    a_r1_needs_armed: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_lost_o |-> armed);

    // R2: the arming boundary never yields a pulse
    a_r2_arm_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (synch_i && !armed) |=> !cycle_lost_o);

    // R4: a started interval closes without a pulse
    a_r4_started_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (synch_i && state == ST_STARTED) |=> !cycle_lost_o);

    // R8: a start outside a boundary suppresses any pulse
    a_r8_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !synch_i) |=> !cycle_lost_o);

    generate
        if (!PREDICT_EN) begin : g_chk_nopred
            // R9: without prediction, pulses follow a boundary only
            a_r9_only_after_synch: assert property (@(posedge clk) disable iff (!rst_n)
                cycle_lost_o |-> $past(synch_i));
        end
    endgenerate

endmodule

// File: tb/tb_cycle_loss_detector.sv
module tb_cycle_loss_detector;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic synch = 1'b0, start = 1'b0, subgap = 1'b0, arbgap = 1'b0, pkt = 1'b0;
    logic lost_p, lost_np;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    string cur_req  = "R1";

    always #4 clk = ~clk;

    cycle_loss_detector #(.PREDICT_EN(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .synch_i(synch), .start_i(start),
        .subgap_i(subgap), .arbgap_i(arbgap), .pkt_i(pkt), .cycle_lost_o(lost_p)
    );

    cycle_loss_detector #(.PREDICT_EN(1'b0)) dut_np (
        .clk(clk), .rst_n(rst_n), .synch_i(synch), .start_i(start),
        .subgap_i(subgap), .arbgap_i(arbgap), .pkt_i(pkt), .cycle_lost_o(lost_np)
    );

    // behavioural reference: index 0 predicts, index 1 does not
    bit m_armed [2];
    bit m_started [2];
    bit m_rep [2];
    bit m_exp [2];
    int m_subs [2];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < 2; k++) begin
                m_armed[k] = 0; m_started[k] = 0; m_rep[k] = 0;
                m_exp[k] = 0; m_subs[k] = 0;
            end
        end else begin
            for (int k = 0; k < 2; k++) begin
                bit fail;
                fail = 0;
                m_exp[k] = 0;
                if (synch) begin
                    if (m_armed[k] && !m_started[k] && !m_rep[k]) m_exp[k] = 1;
                    m_armed[k] = 1; m_rep[k] = 0;
                    m_started[k] = start; m_subs[k] = 0;
                end else if (start) begin
                    m_started[k] = 1;
                end else if (m_armed[k] && !m_started[k]) begin
                    if (arbgap) fail = 1;
                    else if (m_subs[k] >= 1 && (subgap || pkt)) fail = 1;
                    else if (subgap) m_subs[k] = m_subs[k] + 1;
                    if (fail && k == 0 && !m_rep[k]) begin
                        m_exp[k] = 1; m_rep[k] = 1;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            n_checks++;
            if (lost_p !== m_exp[0]) begin
                n_fail++;
                $display("FAIL %s predict-on: cycle_lost_o=%b expected %b at %0t", cur_req, lost_p, m_exp[0], $time);
            end
            n_checks++;
            if (lost_np !== m_exp[1]) begin
                n_fail++;
                $display("FAIL %s predict-off: cycle_lost_o=%b expected %b at %0t", cur_req, lost_np, m_exp[1], $time);
            end
        end
    end

    task automatic drive(input bit s, input bit st, input bit sg, input bit ag, input bit pk);
        @(negedge clk);
        synch = s; start = st; subgap = sg; arbgap = ag; pkt = pk;
        @(negedge clk);
        synch = 0; start = 0; subgap = 0; arbgap = 0; pkt = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired while on %s", cur_req);
        finish_run();
    end

    initial begin
        cur_req = "R1";
        idle(4);
        rst_n = 1'b1;
        idle(3);

        cur_req = "R10";                  // strobes before arming
        drive(0, 0, 1, 0, 0); drive(0, 0, 1, 0, 0);
        drive(0, 0, 0, 1, 0); drive(0, 0, 0, 0, 1);
        idle(2);

        cur_req = "R2";                   // first boundary arms only
        drive(1, 0, 0, 0, 0); idle(3);

        cur_req = "R3";                   // no start since last boundary
        drive(1, 0, 0, 0, 0); idle(3);
        drive(1, 0, 0, 0, 0); idle(3);

        cur_req = "R4";                   // start saves the interval
        drive(0, 1, 0, 0, 0); drive(1, 0, 0, 0, 0);
        drive(1, 1, 0, 0, 0); idle(2);    // start with boundary counts for new one
        drive(1, 0, 0, 0, 0); idle(2);

        cur_req = "R5";                   // sub gap then sub gap
        drive(0, 0, 1, 0, 0); drive(0, 0, 1, 0, 0); idle(2);
        cur_req = "R7";                   // no second report at boundary
        drive(1, 0, 0, 0, 0); idle(2);
        cur_req = "R10";                  // packet before first gap ignored
        drive(0, 0, 0, 0, 1); idle(1);
        cur_req = "R5";                   // sub gap then other packet
        drive(0, 0, 1, 0, 0); drive(0, 0, 0, 0, 1);
        cur_req = "R7";
        drive(0, 0, 1, 0, 0); drive(0, 0, 0, 1, 0); idle(2);

        cur_req = "R6";                   // arbitration reset gap directly
        drive(1, 0, 0, 0, 0); drive(0, 0, 0, 1, 0); idle(2);
        drive(1, 0, 0, 0, 0); drive(0, 0, 1, 0, 0); drive(0, 0, 0, 1, 0); idle(2);

        cur_req = "R8";                   // start coinciding with trigger
        drive(1, 0, 0, 0, 0); drive(0, 0, 1, 0, 0); drive(0, 1, 1, 0, 0);
        drive(0, 0, 0, 1, 0); drive(1, 0, 0, 0, 0); idle(2);

        cur_req = "R9";                   // prediction off: boundary only
        drive(0, 0, 0, 1, 0); idle(2); drive(1, 0, 0, 0, 0); idle(2);

        cur_req = "R3/R5/R6/R7";          // sparse random mix
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            synch  = ($urandom_range(0, 19) == 0);
            start  = ($urandom_range(0, 14) == 0);
            subgap = ($urandom_range(0, 5) == 0);
            arbgap = ($urandom_range(0, 29) == 0);
            pkt    = ($urandom_range(0, 7) == 0);
        end
        @(negedge clk);
        synch = 0; start = 0; subgap = 0; arbgap = 0; pkt = 0;
        idle(3);

        cur_req = "R1";                   // reset mid-run clears everything
        rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
        drive(1, 0, 0, 0, 0); idle(2);

        finish_run();
    end

endmodule